// File: doc/BRIEF.md
# Packet Page Allocator

This block keeps track of a packet buffer that is split into equal pages of 2 KB. A client asks for a page and receives the lowest-numbered free page number one cycle later. If no page is free, it receives a failure pulse instead. Pages go back into the pool by number. Asking to return a page that is already free changes nothing except a sticky error flag.

Beside the pool, the block holds two FIFOs of page numbers. One queues packets waiting to be transmitted. The other queues received packets waiting for the host. The head of each queue is visible at all times. Two interrupt levels are derived from the queue state: one for pending receive work and one for a transmit queue that has drained. The total buffer size and the current free space are reported in 512-byte units. One page therefore counts as four units.

The defaults are 64 pages of 2 KB, which is 128 KB. Each queue is 64 entries deep and 6 bits wide.

Top module: `pkt_page_allocator`

## Requirements
- R1: After synchronous reset all pages are free, `mem_free_units` is 256, both queues are empty, and `alloc_valid`, `alloc_fail`, `dbl_free_err`, `int_rx` and `int_tx_empty` are low.
- R2: When `alloc_req` is sampled high and a page is free, `alloc_valid` is high for one cycle on the next cycle. In that same cycle `alloc_page` carries the lowest-numbered page that was free, and the page becomes allocated.
- R3: When `alloc_req` is sampled high and no page is free, `alloc_fail` is high for one cycle on the next cycle, and `alloc_valid` stays low. The two are never high together.
- R4: `mem_free_units` always equals four times the number of free pages. An allocation and a release in the same cycle both take effect. The page being released in that cycle is not eligible for that cycle's allocation.
- R5: Releasing a page that is already free leaves the free count unchanged. It sets `dbl_free_err`, which then stays high until reset.
- R6: Each queue returns page numbers in arrival order, holds up to 64 entries and shows its oldest entry on its head output. `full` is high at 64 entries and `empty` is high at 0 entries. A push to a full queue is ignored, and a pop from an empty queue is ignored. A push and a pop in the same cycle on a non-empty queue both take effect.
- R7: `int_rx` is high exactly while the receive queue is non-empty.
- R8: `int_tx_empty` is high while the transmit queue is empty, but only once at least one push has been accepted since reset. It is therefore low after reset until the first transmit push.
- R9: `mem_size_units` is constant at 256, which is 128 KB in 512-byte units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Request one page |
| alloc_valid | output | 1 | Allocation granted (one-cycle pulse) |
| alloc_page | output | 6 | Granted page number |
| alloc_fail | output | 1 | Allocation refused, memory full (one-cycle pulse) |
| free_req | input | 1 | Release a page |
| free_page | input | 6 | Page number to release |
| dbl_free_err | output | 1 | Sticky: an already-free page was released |
| mem_size_units | output | 9 | Total buffer size in 512-byte units |
| mem_free_units | output | 9 | Free space in 512-byte units |
| tx_push | input | 1 | Append to the transmit queue |
| tx_push_page | input | 6 | Page number to append |
| tx_pop | input | 1 | Remove the transmit head |
| tx_head | output | 6 | Oldest transmit entry |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_push | input | 1 | Append to the receive queue |
| rx_push_page | input | 6 | Page number to append |
| rx_pop | input | 1 | Remove the receive head |
| rx_head | output | 6 | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| int_rx | output | 1 | Receive work pending |
| int_tx_empty | output | 1 | Transmit queue has drained |

## Verification
An allocation and a release can arrive in the same cycle. The bench provokes this by releasing page 0 while requesting a page. The grant must then come from the next free page, and the free count must end up unchanged. Each queue can also see a push and a pop together, both on a non-empty queue and on an empty one. A reference model built from deques judges the head, the fill flags and the interrupts after every clock.

// File: rtl/pga_pkg.sv
package pga_pkg;

    localparam int unsigned PGA_PAGES       = 64;
    localparam int unsigned PGA_PAGE_BYTES  = 2048;
    localparam int unsigned PGA_UNIT_BYTES  = 512;
    localparam int unsigned PGA_QUEUE_DEPTH = 64;

    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_PUSH = 2'd1,
        Q_POP  = 2'd2,
        Q_BOTH = 2'd3
    } qop_e;

    // Accepted queue operation: push only when room, pop only when data.
    function automatic qop_e qop_decode(input logic push, input logic pop,
                                        input logic full, input logic empty);
        logic do_push;
        logic do_pop;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        return qop_e'({do_pop, do_push});
    endfunction

endpackage

// File: rtl/pga_page_map.sv
module pga_page_map #(
    parameter  int PAGES = 64,
    localparam int IDX_W = $clog2(PAGES),
    localparam int CNT_W = $clog2(PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic             free_req,
    input  logic [IDX_W-1:0] free_page,
    output logic             alloc_valid,
    output logic             alloc_fail,
    output logic [IDX_W-1:0] alloc_page,
    output logic [CNT_W-1:0] free_cnt,
    output logic             dbl_free
);

    logic [PAGES-1:0] free_map;
    logic             any_free;
    logic [IDX_W-1:0] low_idx;
    logic             grant;
    logic             rel_ok;
    logic [PAGES-1:0] set_mask;
    logic [PAGES-1:0] clr_mask;

    // Priority search: lowest set bit wins.
    always_comb begin
        any_free = 1'b0;
        low_idx  = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (free_map[i]) begin
                any_free = 1'b1;
                low_idx  = IDX_W'(i);
            end
        end
    end

    assign grant    = alloc_req && any_free;
    assign rel_ok   = free_req && !free_map[free_page];
    assign clr_mask = grant  ? (PAGES'(1) << low_idx)   : '0;
    assign set_mask = rel_ok ? (PAGES'(1) << free_page) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_map    <= '1;
            free_cnt    <= CNT_W'(PAGES);
            alloc_valid <= 1'b0;
            alloc_fail  <= 1'b0;
            alloc_page  <= '0;
            dbl_free    <= 1'b0;
        end else begin
            free_map    <= (free_map & ~clr_mask) | set_mask;
            free_cnt    <= free_cnt - CNT_W'(grant) + CNT_W'(rel_ok);
            alloc_valid <= grant;
            alloc_fail  <= alloc_req && !any_free;
            if (grant) begin
                alloc_page <= low_idx;
            end
            if (free_req && free_map[free_page]) begin
                dbl_free <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pga_page_fifo.sv
module pga_page_fifo
    import pga_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int W     = 6,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    qop_e             op;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];
    assign op    = qop_decode(push, pop, full, empty);

    always_ff @(posedge clk) begin
        if (op == Q_PUSH || op == Q_BOTH) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            unique case (op)
                Q_PUSH: begin
                    wr_ptr <= bump(wr_ptr);
                    cnt    <= cnt + 1'b1;
                end
                Q_POP: begin
                    rd_ptr <= bump(rd_ptr);
                    cnt    <= cnt - 1'b1;
                end
                Q_BOTH: begin
                    wr_ptr <= bump(wr_ptr);
                    rd_ptr <= bump(rd_ptr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pkt_page_allocator.sv
module pkt_page_allocator
    import pga_pkg::*;
#(
    parameter  int PAGES      = PGA_PAGES,
    parameter  int PAGE_BYTES = PGA_PAGE_BYTES,
    parameter  int UNIT_BYTES = PGA_UNIT_BYTES,
    parameter  int Q_DEPTH    = PGA_QUEUE_DEPTH,
    localparam int IDX_W      = $clog2(PAGES),
    localparam int CNT_W      = $clog2(PAGES + 1),
    localparam int UPP        = PAGE_BYTES / UNIT_BYTES,
    localparam int MEM_UNITS  = PAGES * UPP,
    localparam int UNIT_W     = $clog2(MEM_UNITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic              alloc_valid,
    output logic [IDX_W-1:0]  alloc_page,
    output logic              alloc_fail,
    input  logic              free_req,
    input  logic [IDX_W-1:0]  free_page,
    output logic              dbl_free_err,
    output logic [UNIT_W-1:0] mem_size_units,
    output logic [UNIT_W-1:0] mem_free_units,
    input  logic              tx_push,
    input  logic [IDX_W-1:0]  tx_push_page,
    input  logic              tx_pop,
    output logic [IDX_W-1:0]  tx_head,
    output logic              tx_empty,
    output logic              tx_full,
    input  logic              rx_push,
    input  logic [IDX_W-1:0]  rx_push_page,
    input  logic              rx_pop,
    output logic [IDX_W-1:0]  rx_head,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              int_rx,
    output logic              int_tx_empty
);

    localparam int QN = 2;  // index 0: transmit, 1: receive

    logic [CNT_W-1:0] free_cnt;
    logic [QN-1:0]    q_push;
    logic [QN-1:0]    q_pop;
    logic [IDX_W-1:0] q_din  [QN];
    logic [IDX_W-1:0] q_head [QN];
    logic [QN-1:0]    q_empty;
    logic [QN-1:0]    q_full;
    logic             tx_armed;

    pga_page_map #(.PAGES(PAGES)) u_map (
        .clk         (clk),
        .rst         (rst),
        .alloc_req   (alloc_req),
        .free_req    (free_req),
        .free_page   (free_page),
        .alloc_valid (alloc_valid),
        .alloc_fail  (alloc_fail),
        .alloc_page  (alloc_page),
        .free_cnt    (free_cnt),
        .dbl_free    (dbl_free_err)
    );

    assign q_push = {rx_push, tx_push};
    assign q_pop  = {rx_pop, tx_pop};
    assign q_din[0] = tx_push_page;
    assign q_din[1] = rx_push_page;

    for (genvar g = 0; g < QN; g++) begin : g_queue
        pga_page_fifo #(.DEPTH(Q_DEPTH), .W(IDX_W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[g]),
            .din   (q_din[g]),
            .pop   (q_pop[g]),
            .head  (q_head[g]),
            .empty (q_empty[g]),
            .full  (q_full[g])
        );
    end

    assign tx_head  = q_head[0];
    assign tx_empty = q_empty[0];
    assign tx_full  = q_full[0];
    assign rx_head  = q_head[1];
    assign rx_empty = q_empty[1];
    assign rx_full  = q_full[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_armed <= 1'b0;
        end else if (tx_push && (!tx_full || (tx_pop && !tx_empty))) begin
            tx_armed <= 1'b1;
        end
    end

    assign int_rx         = !rx_empty;
    assign int_tx_empty   = tx_empty && tx_armed;
    assign mem_size_units = UNIT_W'(MEM_UNITS);
    assign mem_free_units = UNIT_W'(int'(free_cnt) * UPP);

endmodule

// File: rtl/pga_checker.sv
module pga_checker #(
    parameter int UNIT_W = 9,
    parameter int UPP    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_valid,
    input logic              alloc_fail,
    input logic              free_req,
    input logic              dbl_free_err,
    input logic [UNIT_W-1:0] mem_free_units,
    input logic              tx_push,
    input logic              tx_pop,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              int_tx_empty
);

    a_r3_grant_excl_fail: assert property (@(posedge clk) disable iff (rst)
        !(alloc_valid && alloc_fail));

    a_r3_fail_only_when_full: assert property (@(posedge clk) disable iff (rst)
        alloc_fail |-> ($past(mem_free_units) == '0));

    a_r4_grant_takes_page: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !$past(free_req))
            |-> (mem_free_units == $past(mem_free_units) - UNIT_W'(UPP)));

    a_r5_error_sticky: assert property (@(posedge clk) disable iff (rst)
        dbl_free_err |=> dbl_free_err);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_push && !tx_pop) |=> tx_full);

    a_r8_irq_on_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(int_tx_empty) |-> $past(!tx_empty));

endmodule

bind pkt_page_allocator pga_checker #(.UNIT_W(UNIT_W), .UPP(UPP)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .alloc_valid    (alloc_valid),
    .alloc_fail     (alloc_fail),
    .free_req       (free_req),
    .dbl_free_err   (dbl_free_err),
    .mem_free_units (mem_free_units),
    .tx_push        (tx_push),
    .tx_pop         (tx_pop),
    .tx_full        (tx_full),
    .tx_empty       (tx_empty),
    .int_tx_empty   (int_tx_empty)
);

// File: tb/tb_pkt_page_allocator.sv
module tb_pkt_page_allocator;

    localparam int NP = 64;
    localparam int QD = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       alloc_req = 0, free_req = 0;
    logic [5:0] free_page = 0;
    logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [5:0] tx_push_page = 0, rx_push_page = 0;
    logic       alloc_valid, alloc_fail, dbl_free_err;
    logic [5:0] alloc_page, tx_head, rx_head;
    logic [8:0] mem_size_units, mem_free_units;
    logic       tx_empty, tx_full, rx_empty, rx_full, int_rx, int_tx_empty;

    int checks = 0;
    int fails  = 0;

    // reference state
    bit [NP-1:0] m_free;
    int          m_cnt;
    bit          e_valid, e_fail, e_err, m_armed;
    int          e_page;
    int          txq[$];
    int          rxq[$];

    always #4 clk = ~clk;

    pkt_page_allocator dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_valid(alloc_valid), .alloc_page(alloc_page),
        .alloc_fail(alloc_fail), .free_req(free_req), .free_page(free_page),
        .dbl_free_err(dbl_free_err), .mem_size_units(mem_size_units),
        .mem_free_units(mem_free_units),
        .tx_push(tx_push), .tx_push_page(tx_push_page), .tx_pop(tx_pop),
        .tx_head(tx_head), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_push(rx_push), .rx_push_page(rx_push_page), .rx_pop(rx_pop),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full),
        .int_rx(int_rx), .int_tx_empty(int_tx_empty)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_free = '1; m_cnt = NP; e_valid = 0; e_fail = 0; e_err = 0;
        m_armed = 0; e_page = 0; txq.delete(); rxq.delete();
    endtask

    task automatic q_step(ref int q[$], input bit push, input bit pop, input int val,
                          output bit pushed);
        bit popped;
        popped = pop && q.size() > 0;
        pushed = push && (q.size() < QD || popped);
        if (popped) void'(q.pop_front());
        if (pushed) q.push_back(val);
    endtask

    task automatic compare();
        chk("R2", "alloc_valid", alloc_valid, e_valid);
        if (e_valid) chk("R2", "alloc_page", alloc_page, e_page);
        chk("R3", "alloc_fail", alloc_fail, e_fail);
        chk("R4", "mem_free_units", mem_free_units, m_cnt * 4);
        chk("R5", "dbl_free_err", dbl_free_err, e_err);
        chk("R9", "mem_size_units", mem_size_units, 256);
        chk("R6", "tx_empty", tx_empty, txq.size() == 0);
        chk("R6", "tx_full", tx_full, txq.size() == QD);
        if (txq.size() > 0) chk("R6", "tx_head", tx_head, txq[0]);
        chk("R6", "rx_empty", rx_empty, rxq.size() == 0);
        chk("R6", "rx_full", rx_full, rxq.size() == QD);
        if (rxq.size() > 0) chk("R6", "rx_head", rx_head, rxq[0]);
        chk("R7", "int_rx", int_rx, rxq.size() > 0);
        chk("R8", "int_tx_empty", int_tx_empty, (txq.size() == 0) && m_armed);
    endtask

    // one clock: update model from current inputs, clock, compare
    task automatic step();
        int  low;
        bit  pushed;
        low = -1;
        for (int i = NP - 1; i >= 0; i--) if (m_free[i]) low = i;
        e_valid = alloc_req && low >= 0;
        e_fail  = alloc_req && low < 0;
        if (free_req) begin
            if (m_free[free_page]) e_err = 1;
            else begin m_free[free_page] = 1; m_cnt++; end
        end
        if (e_valid) begin m_free[low] = 0; m_cnt--; e_page = low; end
        q_step(txq, tx_push, tx_pop, int'(tx_push_page), pushed);
        if (pushed) m_armed = 1;
        q_step(rxq, rx_push, rx_pop, int'(rx_push_page), pushed);
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic idle();
        alloc_req = 0; free_req = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 0;
        compare();                                  // R1 reset state
        chk("R1", "mem_free_units reset", mem_free_units, 256);
        step();

        // R2: lowest pages handed out in order
        for (int i = 0; i < 3; i++) begin idle(); alloc_req = 1; step(); end
        idle(); step();
        // release page 1 then allocate: lowest free is 1 again
        idle(); free_req = 1; free_page = 1; step();
        idle(); alloc_req = 1; step();
        chk("R2", "realloc page", alloc_page, 1);
        // R5: release of already-free page
        idle(); free_req = 1; free_page = 6'd40; step();
        chk("R5", "free count unchanged", mem_free_units, (NP - 3) * 4);
        idle(); step();
        // R4: alloc + release in same cycle; page 0 not eligible
        idle(); alloc_req = 1; free_req = 1; free_page = 0; step();
        chk("R4", "same-cycle grant", alloc_page, 3);
        // drain the pool until failure (R3)
        for (int i = 0; i < 70; i++) begin idle(); alloc_req = 1; step(); end
        chk("R3", "full fail", alloc_fail, 1);
        // release everything, interleaving allocations
        for (int i = 0; i < NP; i++) begin
            idle(); free_req = 1; free_page = 6'(i); alloc_req = (i % 8 == 7); step();
        end
        idle(); step();

        // R6/R8: transmit queue fill, overflow, simultaneous, drain, underflow
        for (int i = 0; i < QD + 2; i++) begin
            idle(); tx_push = 1; tx_push_page = 6'(i ^ 42); step();
        end
        idle(); tx_push = 1; tx_pop = 1; tx_push_page = 6'd9; step();
        for (int i = 0; i < QD + 2; i++) begin idle(); tx_pop = 1; step(); end
        chk("R8", "tx drained irq", int_tx_empty, 1);
        idle(); tx_push = 1; tx_pop = 1; tx_push_page = 6'd5; step();
        idle(); tx_pop = 1; step();

        // R6/R7: receive queue with mixed traffic
        for (int i = 0; i < 40; i++) begin
            idle(); rx_push = 1; rx_push_page = 6'(i * 7); rx_pop = (i % 3 == 2); step();
        end
        for (int i = 0; i < 30; i++) begin idle(); rx_pop = 1; step(); end
        chk("R7", "rx irq cleared", int_rx, 0);

        // R1 again: reset in mid-operation
        idle(); tx_push = 1; alloc_req = 1; step();
        idle(); rst = 1; @(posedge clk); #2 rst = 0;
        model_reset();
        compare();
        chk("R1", "int_tx_empty after reset", int_tx_empty, 0);
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule